// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Registers

This block is the software-visible register front of a bus-master disk DMA engine. A host writes and reads bytes through a plain address/data port. Behind that port sit three registers: a control byte that starts and stops the engine and picks the transfer direction, a status byte, and a 32-bit pointer to the descriptor table in memory. The engine reads the run request, the direction and the table base from dedicated outputs. It reports end of table, error and interrupt through single-cycle event inputs.

The status byte holds three kinds of bit. The active flag is engine state that software can only read. The error and interrupt flags are set by events and cleared by writing ones. Two drive-capability flags and two auxiliary flags are plain storage. From the status byte the block derives an interrupt line and a completion verdict: a good/bad flag plus a failure code. It also derives a flag that tells a timeout handler the engine still counts as busy. The expected sequence is: write the table pointer, issue the drive command, set the run bit, wait for the interrupt, clear the run bit, and take the verdict.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset every register reads 0x00, `eng_run`, `eng_to_mem` and `irq_out` are low, and `table_base` is zero.
- R2: Writing the control byte (offset 0x0) with bit 0 set drives `eng_run` high and sets status bit 0 (active) on the following cycle. Writing it with bit 0 clear drops `eng_run` and clears the active bit on the following cycle.
- R3: Control bit 3 (1 = device to memory) is stored and driven on `eng_to_mem` only when bit 0 was clear before the write. While the engine runs, a write leaves the direction unchanged. The control byte reads back bits 0 and 3, and zero elsewhere.
- R4: An `eng_done` pulse clears the active bit on the next cycle and leaves the run bit set. The active bit is read-only.
- R5: An `eng_err` or `eng_irq` pulse sets status bit 1 or bit 2 respectively. Writing a 1 to one of those bits at status offset 0x2 clears it, and writing a 0 leaves it unchanged. An event in the same cycle as a clearing write wins, and the bit stays set.
- R6: Status bits 5 and 6 (drive capability) and bits 3 and 4 (auxiliary) are read/write storage. Status bit 7 always reads 0.
- R7: `irq_out` follows status bit 2.
- R8: `done_ok` is high when status bits 2:0 equal 3'b100. `done_code` is then 0x00. Otherwise `done_code` is 0x10 ORed with the status byte.
- R9: `still_busy` is high exactly when status bits 3 and 4 are both set.
- R10: The table pointer occupies offsets 0x4 to 0x7, least significant byte first. Bits 1:0 of the pointer always read as zero. `table_base` shows the stored pointer, and the pointer changes only when one of its bytes is written.
- R11: Offsets 0x1, 0x3 and 0x8 to 0xF read 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte offset of the access |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| eng_run | output | 1 | Run request to the engine |
| eng_to_mem | output | 1 | Direction, 1 = device to memory |
| table_base | output | 32 | Descriptor table base address |
| eng_done | input | 1 | End-of-table pulse from the engine |
| eng_err | input | 1 | Error pulse from the engine |
| eng_irq | input | 1 | Interrupt pulse from the engine |
| irq_out | output | 1 | Interrupt request |
| done_ok | output | 1 | Completion verdict, 1 = good |
| done_code | output | 8 | 0x00 on good completion, else 0x10 OR status |
| still_busy | output | 1 | Busy marker for a timeout check |

## Verification
The assertions assume that `eng_done`, `eng_err` and `eng_irq` are synchronous single-cycle pulses. They also assume that `host_we` is a one-cycle strobe with a stable address and data in that cycle. The properties then tie each event to the status bit it must set, and tie a run-state write to the direction it must not change. The directed tasks drive every strobe and pulse for exactly one cycle from the falling edge. The one deliberate collision, an interrupt event during its own clearing write, is built on purpose to check set-over-clear priority.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;
  // byte offsets of the host-visible registers
  localparam int CTL_OFS  = 0;
  localparam int STAT_OFS = 2;
  localparam int PTR_OFS  = 4;

  // control byte fields
  localparam int CTL_RUN  = 0;
  localparam int CTL_DIR  = 3;

  // status byte fields
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_AUX0  = 3;
  localparam int ST_AUX1  = 4;
  localparam int ST_CAP0  = 5;
  localparam int ST_CAP1  = 6;

  // verdict encoding
  localparam logic [2:0] GOOD_END = 3'b100;
  localparam logic [7:0] FAIL_TAG = 8'h10;
endpackage

// File: rtl/bmdma_ctl_reg.sv
module bmdma_ctl_reg
  import bmdma_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run_q,
  output logic              dir_q,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic [DATA_W-1:0] rd_data
);
  logic run_d, dir_d, run_en, dir_en;
  logic unused_ctl_bits;

  assign unused_ctl_bits = ^wr_data;

  always_comb begin
    run_en      = wr_en;
    run_d       = wr_data[CTL_RUN];
    dir_en      = wr_en && !run_q;
    dir_d       = wr_data[CTL_DIR];
    start_pulse = wr_en &&  wr_data[CTL_RUN] && !run_q;
    stop_pulse  = wr_en && !wr_data[CTL_RUN];
    rd_data          = '0;
    rd_data[CTL_RUN] = run_q;
    rd_data[CTL_DIR] = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  // direction is frozen for a cycle that began with the engine running
  assert_dir_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(dir_q));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_irq,
  output logic [DATA_W-1:0] stat_byte
);
  logic       act_q, err_q, irq_q;
  logic [1:0] aux_q, cap_q;
  logic       act_d, err_d, irq_d;
  logic       act_en, err_en, irq_en, rw_en;
  logic       unused_stat_bits;

  assign unused_stat_bits = ^wr_data;

  always_comb begin
    // end of table or a stop request wins over a start
    act_en = stop_pulse || eng_done || start_pulse;
    act_d  = !(stop_pulse || eng_done);
    // engine events win over write-one-to-clear
    err_en = eng_err || (wr_en && wr_data[ST_ERR]);
    err_d  = eng_err;
    irq_en = eng_irq || (wr_en && wr_data[ST_IRQ]);
    irq_d  = eng_irq;
    rw_en  = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      aux_q <= '0;
      cap_q <= '0;
    end else begin
      if (act_en) act_q <= act_d;
      if (err_en) err_q <= err_d;
      if (irq_en) irq_q <= irq_d;
      if (rw_en) begin
        aux_q <= {wr_data[ST_AUX1], wr_data[ST_AUX0]};
        cap_q <= {wr_data[ST_CAP1], wr_data[ST_CAP0]};
      end
    end
  end

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_ACT]  = act_q;
    stat_byte[ST_ERR]  = err_q;
    stat_byte[ST_IRQ]  = irq_q;
    stat_byte[ST_AUX0] = aux_q[0];
    stat_byte[ST_AUX1] = aux_q[1];
    stat_byte[ST_CAP0] = cap_q[0];
    stat_byte[ST_CAP1] = cap_q[1];
  end

  assert_err_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> stat_byte[ST_ERR]);
  assert_irq_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq |=> stat_byte[ST_IRQ]);
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !stat_byte[ST_ACT]);
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int DATA_W     = 8,
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  localparam int LANES     = PTR_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  base
);
  logic unused_low_bits;
  assign unused_low_bits = ^wr_data[ALIGN_BITS-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q, lane_d;
    always_comb begin
      lane_d = wr_data;
      if (g == 0) lane_d[ALIGN_BITS-1:0] = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[g]) lane_q <= lane_d;
    end
    assign base[g*DATA_W +: DATA_W] = lane_q;
  end

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we == '0) |=> $stable(base));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_regs_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_run,
  output logic              eng_to_mem,
  output logic [PTR_W-1:0]  table_base,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_irq,
  output logic              irq_out,
  output logic              done_ok,
  output logic [DATA_W-1:0] done_code,
  output logic              still_busy
);
  localparam int LANES = PTR_W / DATA_W;

  logic              ctl_we, stat_we;
  logic [LANES-1:0]  lane_we;
  logic              start_pulse, stop_pulse;
  logic [DATA_W-1:0] ctl_rd, stat_byte;

  assign ctl_we  = host_we && (host_addr == ADDR_W'(CTL_OFS));
  assign stat_we = host_we && (host_addr == ADDR_W'(STAT_OFS));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
    assign lane_we[g] = host_we && (host_addr == ADDR_W'(PTR_OFS + g));
  end

  bmdma_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_data(host_wdata),
    .run_q(eng_run), .dir_q(eng_to_mem),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .rd_data(ctl_rd)
  );

  bmdma_stat_reg #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_we), .wr_data(host_wdata),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
    .stat_byte(stat_byte)
  );

  bmdma_ptr_reg #(.DATA_W(DATA_W), .PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wr_data(host_wdata),
    .base(table_base)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(CTL_OFS))  host_rdata = ctl_rd;
    if (host_addr == ADDR_W'(STAT_OFS)) host_rdata = stat_byte;
    for (int i = 0; i < LANES; i++)
      if (host_addr == ADDR_W'(PTR_OFS + i))
        host_rdata = table_base[i*DATA_W +: DATA_W];
  end

  always_comb begin
    irq_out    = stat_byte[ST_IRQ];
    done_ok    = (stat_byte[ST_IRQ:ST_ACT] == GOOD_END);
    done_code  = done_ok ? '0 : (DATA_W'(FAIL_TAG) | stat_byte);
    still_busy = stat_byte[ST_AUX0] && stat_byte[ST_AUX1];
  end

  // a good verdict cannot exist without a raised interrupt line
  assert_verdict_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> irq_out);
  // an interrupt event is visible on the pin one cycle later
  assert_irq_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq |=> irq_out);
endmodule

// File: tb/tb_bmdma_regfile.sv
`timescale 1ns/1ps
module tb_bmdma_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  host_addr;
  logic        host_we;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        eng_run, eng_to_mem;
  logic [31:0] table_base;
  logic        eng_done, eng_err, eng_irq;
  logic        irq_out, done_ok, still_busy;
  logic [7:0]  done_code;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  bmdma_regfile dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_run(eng_run), .eng_to_mem(eng_to_mem), .table_base(table_base),
    .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
    .irq_out(irq_out), .done_ok(done_ok), .done_code(done_code),
    .still_busy(still_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; host_addr = 4'h0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    host_addr = a;
    #0.1;
    check(req, {24'h0, host_rdata}, {24'h0, exp});
    host_addr = 4'h0;
  endtask

  task automatic pulse(input logic d, input logic e, input logic i);
    @(negedge clk);
    eng_done = d; eng_err = e; eng_irq = i;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0; eng_irq = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1 ctl", 4'h0, 8'h00);
    rd_check("R1 stat", 4'h2, 8'h00);
    for (int i = 4; i < 8; i++) rd_check("R1 ptr", 4'(i), 8'h00);
    check("R1 run", eng_run, 0);
    check("R1 dir", eng_to_mem, 0);
    check("R1 irq", irq_out, 0);
    check("R1 base", table_base, 0);
    check("R8 reset verdict", done_ok, 0);
    check("R8 reset code", done_code, 8'h10);
  endtask

  task automatic t_pointer;
    wr(4'h4, 8'h13); wr(4'h5, 8'h57); wr(4'h6, 8'h9B); wr(4'h7, 8'hDF);
    check("R10 base", table_base, 32'hDF9B5710);
    rd_check("R10 low byte aligned", 4'h4, 8'h10);
    rd_check("R10 top byte", 4'h7, 8'hDF);
  endtask

  task automatic t_run_dir;
    wr(4'h0, 8'h08);
    check("R3 dir set idle", eng_to_mem, 1);
    check("R2 still idle", eng_run, 0);
    wr(4'h0, 8'h09);
    check("R2 run", eng_run, 1);
    rd_check("R2 active", 4'h2, 8'h01);
    wr(4'h0, 8'h01);
    check("R3 dir frozen", eng_to_mem, 1);
    rd_check("R3 ctl readback", 4'h0, 8'h09);
  endtask

  task automatic t_done_stop;
    pulse(1'b1, 1'b0, 1'b0);
    rd_check("R4 done clears active", 4'h2, 8'h00);
    check("R4 run kept", eng_run, 1);
    wr(4'h2, 8'h01);
    rd_check("R4 active read-only", 4'h2, 8'h00);
    wr(4'h0, 8'h00);
    check("R2 stop", eng_run, 0);
    wr(4'h0, 8'h01);
    rd_check("R2 restart active", 4'h2, 8'h01);
    wr(4'h0, 8'h00);
    rd_check("R2 stop clears active", 4'h2, 8'h00);
  endtask

  task automatic t_events;
    pulse(1'b0, 1'b0, 1'b1);
    rd_check("R5 irq set", 4'h2, 8'h04);
    check("R7 irq pin", irq_out, 1);
    check("R8 good", done_ok, 1);
    check("R8 good code", done_code, 8'h00);
    pulse(1'b0, 1'b1, 1'b0);
    rd_check("R5 err set", 4'h2, 8'h06);
    check("R8 bad", done_ok, 0);
    check("R8 bad code", done_code, 8'h16);
    wr(4'h2, 8'h00);
    rd_check("R5 zero write keeps", 4'h2, 8'h06);
    wr(4'h2, 8'h02);
    rd_check("R5 clear err", 4'h2, 8'h04);
    @(negedge clk);
    host_addr = 4'h2; host_wdata = 8'h04; host_we = 1'b1; eng_irq = 1'b1;
    @(negedge clk);
    host_we = 1'b0; eng_irq = 1'b0; host_addr = 4'h0;
    rd_check("R5 event beats clear", 4'h2, 8'h04);
    wr(4'h2, 8'h04);
    rd_check("R5 clear irq", 4'h2, 8'h00);
    check("R7 irq pin low", irq_out, 0);
  endtask

  task automatic t_caps;
    wr(4'h2, 8'h60);
    rd_check("R6 caps", 4'h2, 8'h60);
    check("R9 not busy", still_busy, 0);
    wr(4'h2, 8'hFF);
    rd_check("R6 bit7 zero", 4'h2, 8'h78);
    check("R9 busy", still_busy, 1);
    check("R8 code with aux", done_code, 8'h78);
    wr(4'h2, 8'h08);
    rd_check("R6 aux only", 4'h2, 8'h08);
    check("R9 one aux", still_busy, 0);
  endtask

  task automatic t_unmapped;
    wr(4'h1, 8'hFF); wr(4'h3, 8'hFF); wr(4'h8, 8'hFF); wr(4'hF, 8'hFF);
    rd_check("R11 read 1", 4'h1, 8'h00);
    rd_check("R11 read 3", 4'h3, 8'h00);
    rd_check("R11 read 8", 4'h8, 8'h00);
    rd_check("R11 read F", 4'hF, 8'h00);
    rd_check("R11 ctl kept", 4'h0, 8'h00);
    rd_check("R11 stat kept", 4'h2, 8'h08);
    check("R11 base kept", table_base, 32'hDF9B5710);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_we = 1'b0; host_wdata = '0;
    eng_done = 1'b0; eng_err = 1'b0; eng_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_run_dir();
    t_done_stop();
    t_events();
    t_caps();
    t_unmapped();
    finish_run();
  end
endmodule